// File: doc/BRIEF.md
# Hardware Return Stack with Sticky Error Pointer

This block is a small on-chip stack. It holds fifteen 32-bit words, and each word is kept as a high 16-bit half and a low 16-bit half. A 6-bit pointer tracks the stack. Its four low bits give the top location: 1 to 15 are real entries, and 0 means the stack is empty and has no storage. Bit 4 is a sticky error flag and bit 5 is an underflow flag. A controller sends one command per cycle. The commands are idle, a single push or pull, a double push or pull that moves two words in one cycle, a write to either half of the current top entry, and a direct load of the whole pointer.

The top entry and the entry below it can be read at all times. Reading them never changes the pointer. When an operation overflows or underflows the stack, the pointer moves into a fixed error pattern and the error flag is set. On the cycle the error flag goes from 0 to 1, the block raises a one-cycle request for a priority-3 exception.

Once the error flag is set, it holds the underflow flag fixed, so stack moves cannot change it. Only a direct pointer load with bit 4 at zero clears the error flag.

Top module: `sys_stack`

## Requirements
- R1: After reset the pointer reads 000000, the error request is low, and both read ports read zero.
- R2: Command 1 (push) adds one to the pointer and stores word A at the new top. Command 2 (pull) subtracts one from the pointer, so the entry below becomes the top. The top port reads the location named by pointer bits 3..0, or zero when that location is 0. The below port reads the location one lower, or zero when the pointer location is below 2.
- R3: A push with the pointer at 001111 gives 010000. A double push from 001111 gives 010001. Any data aimed at location 0 is dropped.
- R4: A pull with the pointer at 000000 gives 111111. A double pull from 000000 gives 111110.
- R5: Output err_req is high for exactly one cycle, in the same cycle that pointer bit 4 first reads 1 after reading 0. This holds whether the bit was set by an error or by a direct pointer load.
- R6: Pointer bit 4 stays set through every command except command 7 (pointer load) with data bit 4 at zero.
- R7: While bit 4 is set, pushes and pulls leave pointer bit 5 unchanged.
- R8: Command 5 writes the high half and command 6 writes the low half of the top entry, from the high or low half of word A. Neither changes the pointer or raises an error. At location 0 the write is dropped.
- R9: When bit 5 is 1 and bit 4 is 0, the next push or pull sets bit 5 to whether that operation underflowed, which makes it 0 when the operation did not underflow.
- R10: Command 3 (double push) stores word A at location +1 and word B at location +2, then adds two to the pointer. Command 4 (double pull) subtracts two.
- R11: Command 7 loads all six pointer bits from ptr_wdata. Command 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command code, 0 to 7, as listed in the requirements |
| wa_hi_i | input | 16 | High half of word A |
| wa_lo_i | input | 16 | Low half of word A |
| wb_hi_i | input | 16 | High half of word B |
| wb_lo_i | input | 16 | Low half of word B |
| ptr_wdata_i | input | 6 | Value loaded into the pointer by command 7 |
| ptr_o | output | 6 | Pointer: {underflow, error, location[3:0]} |
| top_hi_o | output | 16 | High half of the top entry |
| top_lo_o | output | 16 | Low half of the top entry |
| below_hi_o | output | 16 | High half of the entry below the top |
| below_lo_o | output | 16 | Low half of the entry below the top |
| err_req | output | 1 | One-cycle priority-3 stack error request |

## Verification
A command driven before a clock edge takes effect at that edge, with no other delay. The new pointer, the two read ports and err_req are all valid after that edge, and none of them carries a further register stage. The driver applies each command at the falling edge and queues the expected pointer, read data and request for that edge. The monitor checks every queued item 1 ns after the following rising edge, so each result is compared in exactly the cycle it is due.

// File: rtl/sys_stack_pkg.sv
package sys_stack_pkg;
   typedef enum logic [2:0] {
      SOP_IDLE   = 3'd0,
      SOP_PUSH   = 3'd1,
      SOP_PULL   = 3'd2,
      SOP_PUSH2  = 3'd3,
      SOP_PULL2  = 3'd4,
      SOP_WR_HI  = 3'd5,
      SOP_WR_LO  = 3'd6,
      SOP_WR_PTR = 3'd7
   } stk_op_e;

   function automatic logic op_is_push(stk_op_e op);
      return (op == SOP_PUSH) || (op == SOP_PUSH2);
   endfunction

   function automatic logic op_is_pull(stk_op_e op);
      return (op == SOP_PULL) || (op == SOP_PULL2);
   endfunction
endpackage

// File: rtl/sys_stack_ptr.sv
module sys_stack_ptr
   import sys_stack_pkg::*;
#(
   parameter int LOC_W = 4,
   localparam int PTR_W = LOC_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op,
   input  logic [PTR_W-1:0] ptr_wdata,
   output logic [PTR_W-1:0] ptr_q,
   output logic             err_req_q
);
   localparam int CNT_W = LOC_W + 1;

   generate
      if (LOC_W < 2 || LOC_W > 8) begin : g_bad_loc
         $error("sys_stack_ptr: LOC_W must lie in 2..8");
      end
   endgenerate

   logic             se_q, uf_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   step, add_r, sub_r;
   logic [PTR_W-1:0] ptr_d;

   assign se_q  = ptr_q[LOC_W];
   assign uf_q  = ptr_q[LOC_W+1];
   assign cnt_q = ptr_q[CNT_W-1:0];

   // error flag and location count move as one field; bit above them is the borrow
   always_comb begin
      step  = ((op == SOP_PUSH2) || (op == SOP_PULL2)) ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
      add_r = {1'b0, cnt_q} + step;
      sub_r = {1'b0, cnt_q} - step;
      ptr_d = ptr_q;
      case (op)
         SOP_PUSH, SOP_PUSH2:
            ptr_d = {se_q ? uf_q : 1'b0, se_q | add_r[LOC_W], add_r[LOC_W-1:0]};
         SOP_PULL, SOP_PULL2:
            ptr_d = {se_q ? uf_q : sub_r[CNT_W], se_q | sub_r[LOC_W], sub_r[LOC_W-1:0]};
         SOP_WR_PTR:
            ptr_d = ptr_wdata;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         err_req_q <= 1'b0;
      end else begin
         ptr_q     <= ptr_d;
         err_req_q <= ptr_d[LOC_W] & ~se_q;
      end
   end

   // R6: error flag holds unless software loads a zero into it
   p_se_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (se_q && !(op == SOP_WR_PTR && !ptr_wdata[LOC_W])) |=> se_q);

   // R7: underflow flag frozen by the error flag during moves
   p_uf_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (se_q && (op_is_push(op) || op_is_pull(op))) |=> $stable(uf_q));

   // R4: single pull on empty
   p_pull_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_PULL && ptr_q == '0) |=> ptr_q == {PTR_W{1'b1}});

   // R3: single push on full
   p_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_PUSH && ptr_q == {2'b00, {LOC_W{1'b1}}})
      |=> ptr_q == {2'b01, {LOC_W{1'b0}}});

   // R5: request fires exactly on the rise of the error flag
   p_req_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(se_q) |-> err_req_q);
   p_req_only_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_req_q |-> $rose(se_q));

   // R8: half writes leave the pointer alone
   p_half_wr_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_WR_HI || op == SOP_WR_LO) |=> $stable(ptr_q));
endmodule

// File: rtl/sys_stack_mem.sv
module sys_stack_mem
   import sys_stack_pkg::*;
#(
   parameter int LOC_W          = 4,
   parameter int HALF_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int WORD_W = 2 * HALF_W,
   localparam int DEPTH  = (1 << LOC_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op,
   input  logic [LOC_W-1:0]  loc,
   input  logic [WORD_W-1:0] word_a,
   input  logic [WORD_W-1:0] word_b,
   output logic [WORD_W-1:0] top_o,
   output logic [WORD_W-1:0] below_o
);
   logic [WORD_W-1:0] ent   [1:DEPTH];
   logic [WORD_W-1:0] ent_d [1:DEPTH];
   logic [LOC_W-1:0]  addr_a, addr_b, loc_m1;
   logic [DEPTH:1]    we_a, we_b, we_hi, we_lo;

   assign addr_a = loc + LOC_W'(1);
   assign addr_b = loc + LOC_W'(2);
   assign loc_m1 = loc - LOC_W'(1);

   // location 0 has no storage: its decode bit simply does not exist
   generate
      for (genvar g = 1; g <= DEPTH; g++) begin : g_dec
         assign we_a[g]  = op_is_push(op) && (addr_a == LOC_W'(g));
         assign we_b[g]  = (op == SOP_PUSH2) && (addr_b == LOC_W'(g));
         assign we_hi[g] = (op == SOP_WR_HI) && (loc == LOC_W'(g));
         assign we_lo[g] = (op == SOP_WR_LO) && (loc == LOC_W'(g));
      end
   endgenerate

   always_comb begin
      for (int i = 1; i <= DEPTH; i++) begin
         ent_d[i] = ent[i];
         if (we_a[i]) ent_d[i] = word_a;
         if (we_b[i]) ent_d[i] = word_b;
         if (we_hi[i]) ent_d[i][WORD_W-1:HALF_W] = word_a[WORD_W-1:HALF_W];
         if (we_lo[i]) ent_d[i][HALF_W-1:0] = word_a[HALF_W-1:0];
      end
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 1; i <= DEPTH; i++) ent[i] <= '0;
            end else begin
               for (int i = 1; i <= DEPTH; i++) ent[i] <= ent_d[i];
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            for (int i = 1; i <= DEPTH; i++) ent[i] <= ent_d[i];
         end
      end
   endgenerate

   assign top_o   = (loc == '0) ? '0 : ent[loc];
   assign below_o = (loc < LOC_W'(2)) ? '0 : ent[loc_m1];

   // R2: a single push shows its word at the new top
   p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_PUSH && addr_a != '0) |=> top_o == $past(word_a));

   // R10: double push leaves B on top and A beneath
   p_push2_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_PUSH2 && addr_a != '0 && addr_b != '0)
      |=> (top_o == $past(word_b)) && (below_o == $past(word_a)));

   // R8: high-half write touches only the high half
   p_wr_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SOP_WR_HI && loc != '0)
      |=> (top_o[WORD_W-1:HALF_W] == $past(word_a[WORD_W-1:HALF_W]))
          && $stable(top_o[HALF_W-1:0]));
endmodule

// File: rtl/sys_stack.sv
module sys_stack
   import sys_stack_pkg::*;
#(
   parameter int LOC_W          = 4,
   parameter int HALF_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTR_W  = LOC_W + 2,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [HALF_W-1:0] wa_hi_i,
   input  logic [HALF_W-1:0] wa_lo_i,
   input  logic [HALF_W-1:0] wb_hi_i,
   input  logic [HALF_W-1:0] wb_lo_i,
   input  logic [PTR_W-1:0]  ptr_wdata_i,
   output logic [PTR_W-1:0]  ptr_o,
   output logic [HALF_W-1:0] top_hi_o,
   output logic [HALF_W-1:0] top_lo_o,
   output logic [HALF_W-1:0] below_hi_o,
   output logic [HALF_W-1:0] below_lo_o,
   output logic              err_req
);
   generate
      if (HALF_W < 1) begin : g_bad_half
         $error("sys_stack: HALF_W must be positive");
      end
   endgenerate

   stk_op_e           op;
   logic [WORD_W-1:0] top_w, below_w;

   assign op = stk_op_e'(op_i);

   sys_stack_ptr #(.LOC_W(LOC_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .ptr_wdata (ptr_wdata_i),
      .ptr_q     (ptr_o),
      .err_req_q (err_req)
   );

   sys_stack_mem #(
      .LOC_W          (LOC_W),
      .HALF_W         (HALF_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .loc     (ptr_o[LOC_W-1:0]),
      .word_a  ({wa_hi_i, wa_lo_i}),
      .word_b  ({wb_hi_i, wb_lo_i}),
      .top_o   (top_w),
      .below_o (below_w)
   );

   assign top_hi_o   = top_w[WORD_W-1:HALF_W];
   assign top_lo_o   = top_w[HALF_W-1:0];
   assign below_hi_o = below_w[WORD_W-1:HALF_W];
   assign below_lo_o = below_w[HALF_W-1:0];
endmodule

// File: tb/sys_stack_tb.sv
module sys_stack_tb;
   import sys_stack_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [15:0] wa_hi_i = '0, wa_lo_i = '0, wb_hi_i = '0, wb_lo_i = '0;
   logic [5:0]  ptr_wdata_i = '0;
   logic [5:0]  ptr_o;
   logic [15:0] top_hi_o, top_lo_o, below_hi_o, below_lo_o;
   logic        err_req;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sys_stack u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i),
      .wa_hi_i(wa_hi_i), .wa_lo_i(wa_lo_i), .wb_hi_i(wb_hi_i), .wb_lo_i(wb_lo_i),
      .ptr_wdata_i(ptr_wdata_i), .ptr_o(ptr_o),
      .top_hi_o(top_hi_o), .top_lo_o(top_lo_o),
      .below_hi_o(below_hi_o), .below_lo_o(below_lo_o), .err_req(err_req)
   );

   typedef struct {
      logic [5:0]  ptr;
      logic [31:0] top;
      logic [31:0] below;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [5:0]  m_ptr;
   logic [31:0] m_mem [16];

   // driver: applies one command and queues the values due after the next rising edge
   task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [5:0] pw, input string tag);
      logic se, uf;
      logic [3:0] loc;
      logic [5:0] nx, ext;
      int k;
      exp_t e;
      @(negedge clk);
      op_i = op; {wa_hi_i, wa_lo_i} = a; {wb_hi_i, wb_lo_i} = b; ptr_wdata_i = pw;
      se = m_ptr[4]; uf = m_ptr[5]; loc = m_ptr[3:0];
      nx = m_ptr;
      k = (op == 3'd3 || op == 3'd4) ? 2 : 1;
      case (op)
         3'd1, 3'd3: begin
            ext = {1'b0, m_ptr[4:0]} + 6'(k);
            nx = {se ? uf : 1'b0, se | ext[4], ext[3:0]};
            if (4'(loc + 4'd1) != 4'd0) m_mem[4'(loc + 4'd1)] = a;
            if (op == 3'd3 && 4'(loc + 4'd2) != 4'd0) m_mem[4'(loc + 4'd2)] = b;
         end
         3'd2, 3'd4: begin
            ext = {1'b0, m_ptr[4:0]} - 6'(k);
            nx = {se ? uf : ext[5], se | ext[4], ext[3:0]};
         end
         3'd5: if (loc != 0) m_mem[loc][31:16] = a[31:16];
         3'd6: if (loc != 0) m_mem[loc][15:0] = a[15:0];
         3'd7: nx = pw;
         default: ;
      endcase
      e.irq = nx[4] & ~se;
      m_ptr = nx;
      e.ptr = nx;
      e.top = (nx[3:0] != 0) ? m_mem[nx[3:0]] : 32'h0;
      e.below = (nx[3:0] >= 2) ? m_mem[4'(nx[3:0] - 4'd1)] : 32'h0;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares one queued item per cycle, away from the edge
   always @(posedge clk) begin
      if (rst_n) begin
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (ptr_o !== e.ptr || {top_hi_o, top_lo_o} !== e.top ||
                {below_hi_o, below_lo_o} !== e.below || err_req !== e.irq) begin
               n_fail++;
               $display("FAIL %s ptr=%b exp %b top=%h exp %h below=%h exp %h req=%b exp %b",
                        e.tag, ptr_o, e.ptr, {top_hi_o, top_lo_o}, e.top,
                        {below_hi_o, below_lo_o}, e.below, err_req, e.irq);
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      m_ptr = '0;
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      n_checks++;   // R1 reset state
      if (ptr_o !== 6'd0 || err_req !== 1'b0 || {top_hi_o, top_lo_o, below_hi_o, below_lo_o} !== '0) begin
         n_fail++;
         $display("FAIL R1 ptr=%b req=%b exp 000000 0", ptr_o, err_req);
      end
      rst_n = 1'b1;

      apply(3'd0, 32'h0, 32'h0, 6'h0, "R11 idle");
      apply(3'd2, 32'h0, 32'h0, 6'h0, "R4 pull empty");          // 111111, request
      apply(3'd0, 32'h0, 32'h0, 6'h0, "R5 one cycle");
      apply(3'd1, 32'h1111_2222, 32'h0, 6'h0, "R7 push while error");
      apply(3'd2, 32'h0, 32'h0, 6'h0, "R7 pull while error");
      apply(3'd7, 32'h0, 32'h0, 6'b010101, "R6 load keeps flag");
      apply(3'd7, 32'h0, 32'h0, 6'b000000, "R6 load clears flag");
      apply(3'd4, 32'h0, 32'h0, 6'h0, "R4 double pull empty");   // 111110
      apply(3'd7, 32'h0, 32'h0, 6'b000000, "R11 load");
      apply(3'd5, 32'hDEAD_0000, 32'h0, 6'h0, "R8 write at empty");
      for (int i = 1; i <= 15; i++)
         apply(3'd1, {16'hA000 + 16'(i), 16'h5000 + 16'(i)}, 32'h0, 6'h0, "R2 push");
      apply(3'd1, 32'hBAD0_BAD0, 32'h0, 6'h0, "R3 push full");   // 010000
      apply(3'd7, 32'h0, 32'h0, 6'b001111, "R11 reload full");
      apply(3'd3, 32'hCCCC_0001, 32'hCCCC_0002, 6'h0, "R3 double push full"); // 010001
      apply(3'd7, 32'h0, 32'h0, 6'b001100, "R11 load 12");
      apply(3'd2, 32'h0, 32'h0, 6'h0, "R2 pull");
      apply(3'd2, 32'h0, 32'h0, 6'h0, "R2 pull");
      apply(3'd4, 32'h0, 32'h0, 6'h0, "R10 double pull");
      apply(3'd3, 32'h3333_4444, 32'h5555_6666, 6'h0, "R10 double push");
      apply(3'd5, 32'h7777_0000, 32'h0, 6'h0, "R8 write high");
      apply(3'd6, 32'h0000_8888, 32'h0, 6'h0, "R8 write low");
      apply(3'd7, 32'h0, 32'h0, 6'b100011, "R9 force underflow only");
      apply(3'd1, 32'h9999_AAAA, 32'h0, 6'h0, "R9 push corrects");
      apply(3'd7, 32'h0, 32'h0, 6'b100101, "R9 force again");
      apply(3'd2, 32'h0, 32'h0, 6'h0, "R9 pull corrects");
      apply(3'd7, 32'h0, 32'h0, 6'b000001, "R11 load 1");
      apply(3'd4, 32'h0, 32'h0, 6'h0, "R4 double pull from 1");
      apply(3'd7, 32'h0, 32'h0, 6'b001110, "R11 load 14");
      apply(3'd3, 32'hEEEE_0001, 32'hEEEE_0002, 6'h0, "R3 double push into 0");
      apply(3'd0, 32'h0, 32'h0, 6'h0, "R5 idle after");
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule